// File: doc/BRIEF.md
# Dual-Byte Event Counter with Cascade Mode

This block counts pulses that arrive on two asynchronous event pins. It holds two 8-bit count bytes, one low and one high. A single mode bit in the control byte selects how they work. With the mode bit clear, the two bytes form one 16-bit counter. The low byte counts pulses on the low pin. The high byte steps once each time the low byte rolls over. With the mode bit set, each byte is a separate 8-bit counter driven by its own pin.

Each byte has its own enable bit. The enable gates whichever clock source feeds that byte, so a disabled byte holds its value. Each pin passes through a two-flop synchronizer and a rising-edge detector in the system clock domain. One detected rising edge counts as one event. A sticky flag records the roll-over of each byte. Software uses a plain register port to read and write the control byte and both count bytes. Reads are combinational. A write takes effect at the next clock edge.

Top module: `evt_counter_pair`

## Requirements
- R1: After reset (rst_n low), the control byte reads 0x00, and both count bytes read 0x00. The mode bit is therefore 0, both enables are 0 and both flags are 0.
- R2: The register address selects the data as follows: 0 is the control byte, 1 is the low count, 2 is the high count, and 3 reads 0x00. In the control byte, bit 4 is the mode, bit 3 is the high enable, bit 2 is the low enable, bit 1 is the high roll-over flag and bit 0 is the low roll-over flag. Bits 7:5 read 0.
- R3: An enabled byte advances by exactly one for each rising edge on its source pin. The new count is visible after the third rising clock edge that follows the pin change. A pin held high adds only one count.
- R4: With the mode bit at 0, the high byte advances by one on the same clock edge on which the low byte wraps from 0xFF to 0x00. Pulses on the high pin have no effect in this mode.
- R5: With the mode bit at 1, the high byte counts rising edges on the high pin. A wrap of the low byte does not change the high byte.
- R6: With the low enable at 0, the low byte keeps its value whatever happens on the low pin.
- R7: With the high enable at 0, the high byte keeps its value whichever source the mode bit selects.
- R8: A byte that wraps from 0xFF to 0x00 sets its roll-over flag. Writing 0 to a flag bit at address 0 clears that flag. Writing 1 leaves it unchanged. A wrap on the same clock edge as a clearing write leaves the flag set.
- R9: A write to a count byte on the same clock edge as an accepted event loads the written value and drops the increment. A write to the low byte on that edge also suppresses its wrap, so no flag is set and no cascade step reaches the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_lo_i | input | 1 | Asynchronous event pin for the low byte |
| evt_hi_i | input | 1 | Asynchronous event pin for the high byte, used only when the mode bit is 1 |
| reg_we | input | 1 | Register write strobe, sampled at the clock edge |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for the register at reg_addr |

## Verification
The bench drives the low byte through 0xFF with both modes and both enable settings. A design that cascaded in the wrong mode would move the high byte, and so would one that ignored the high enable. A design that cascaded one cycle late would show a mismatch on the cycle-by-cycle comparison. The bench also holds a pin high for many cycles to catch a level-sensitive counter.

The bench times register writes to land on the exact edge on which a synchronized event arrives. A wrong write priority shows up as a count off by one. If the wrap is not suppressed, the high byte steps or the flag is set. Clearing writes and writes of 1 to the flags catch a flag that is cleared by the wrong value or that is not sticky.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_MODE  = 4;
  localparam int unsigned BIT_EN_HI = 3;
  localparam int unsigned BIT_EN_LO = 2;
  localparam int unsigned BIT_FL_HI = 1;
  localparam int unsigned BIT_FL_LO = 0;

  typedef struct packed {
    logic split;
    logic en_hi;
    logic en_lo;
    logic flag_hi;
    logic flag_lo;
  } ctrl_t;
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise
);
  localparam int unsigned TOP = STAGES;

  logic [TOP:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[TOP-1:0], pin_async};
  end

  assign rise = sh_q[TOP-1] & ~sh_q[TOP];

  // R3: one pin edge yields a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/evc_count_byte.sv
module evc_count_byte #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             inc,
  output logic [WIDTH-1:0] cnt,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  assign wrap = inc & ~load & (cnt == MAXV);

  // R9: a write beats a same-cycle increment
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R3: accepted event adds exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> cnt == $past(cnt) + 1'b1);
  // R6 / R7: no event and no write means the byte holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt));
  // R8: wrap only when the byte goes to zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
endmodule

// File: rtl/evt_counter_pair.sv
module evt_counter_pair
  import evc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_lo_i,
  input  logic              evt_hi_i,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned NCH = 2;
  localparam int unsigned CH_LO = 0;
  localparam int unsigned CH_HI = 1;

  logic [NCH-1:0] pins;
  logic [NCH-1:0] rise;
  assign pins = {evt_hi_i, evt_lo_i};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    evc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pins[g]), .rise(rise[g])
    );
  end

  ctrl_t ctrl_q;
  logic  wr_ctrl, wr_lo, wr_hi;
  logic  lo_inc, hi_inc, hi_src;
  logic  lo_wrap, hi_wrap;
  logic [DATA_W-1:0] lo_cnt, hi_cnt;

  assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
  assign wr_lo   = reg_we && (reg_addr == REG_LO);
  assign wr_hi   = reg_we && (reg_addr == REG_HI);

  assign lo_inc = rise[CH_LO] & ctrl_q.en_lo;
  assign hi_src = ctrl_q.split ? rise[CH_HI] : lo_wrap;
  assign hi_inc = hi_src & ctrl_q.en_hi;

  evc_count_byte #(.WIDTH(DATA_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .load(wr_lo), .load_val(reg_wdata),
    .inc(lo_inc), .cnt(lo_cnt), .wrap(lo_wrap)
  );

  evc_count_byte #(.WIDTH(DATA_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .load(wr_hi), .load_val(reg_wdata),
    .inc(hi_inc), .cnt(hi_cnt), .wrap(hi_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.split   <= reg_wdata[BIT_MODE];
        ctrl_q.en_hi   <= reg_wdata[BIT_EN_HI];
        ctrl_q.en_lo   <= reg_wdata[BIT_EN_LO];
        ctrl_q.flag_hi <= (ctrl_q.flag_hi & reg_wdata[BIT_FL_HI]) | hi_wrap;
        ctrl_q.flag_lo <= (ctrl_q.flag_lo & reg_wdata[BIT_FL_LO]) | lo_wrap;
      end else begin
        ctrl_q.flag_hi <= ctrl_q.flag_hi | hi_wrap;
        ctrl_q.flag_lo <= ctrl_q.flag_lo | lo_wrap;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      REG_CTRL: reg_rdata = {3'b000, ctrl_q.split, ctrl_q.en_hi, ctrl_q.en_lo,
                             ctrl_q.flag_hi, ctrl_q.flag_lo};
      REG_LO:   reg_rdata = lo_cnt;
      REG_HI:   reg_rdata = hi_cnt;
      default:  reg_rdata = '0;
    endcase
  end

  // R4: in cascade mode the high byte only moves on a low wrap or a write
  a_r4_cascade_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.split && !lo_wrap && !wr_hi) |=> $stable(hi_cnt));
  // R7: high enable off keeps the high byte
  a_r7_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_hi && !wr_hi) |=> $stable(hi_cnt));
  // R8: a low wrap always leaves the flag set
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> ctrl_q.flag_lo);
  // R6: low enable off keeps the low byte
  a_r6_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_lo && !wr_lo) |=> $stable(lo_cnt));
endmodule

// File: tb/test_evt_counter_pair.sv
module test_evt_counter_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_lo_i = 1'b0, evt_hi_i = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  evt_counter_pair i_evt_counter_pair (
    .clk(clk), .rst_n(rst_n), .evt_lo_i(evt_lo_i), .evt_hi_i(evt_hi_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  // behavioural reference: pin history queues, integer counts
  bit q_lo[$], q_hi[$];
  int m_lo = 0, m_hi = 0;
  bit m_mode = 0, m_enh = 0, m_enl = 0, m_fh = 0, m_fl = 0;

  function automatic bit seen_rise(ref bit q[$]);
    // history: [0] oldest; rise when the value two edges old is 1 and three edges old is 0
    return q.size() >= 3 && q[q.size()-2] && !q[q.size()-3];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_lo = {}; q_hi = {};
      m_lo = 0; m_hi = 0; {m_mode, m_enh, m_enl, m_fh, m_fl} = '0;
    end else begin
      bit el, eh, inl, inh, wl, wh, wrl, wrh, src;
      el = seen_rise(q_lo); eh = seen_rise(q_hi);
      wl = reg_we && reg_addr == 1; wh = reg_we && reg_addr == 2;
      inl = el && m_enl;
      wrl = inl && m_lo == 255 && !wl;
      src = m_mode ? eh : wrl;
      inh = src && m_enh;
      wrh = inh && m_hi == 255 && !wh;
      if (wl) m_lo = reg_wdata; else if (inl) m_lo = (m_lo + 1) % 256;
      if (wh) m_hi = reg_wdata; else if (inh) m_hi = (m_hi + 1) % 256;
      if (reg_we && reg_addr == 0) begin
        m_mode = reg_wdata[4]; m_enh = reg_wdata[3]; m_enl = reg_wdata[2];
        m_fh = (m_fh && reg_wdata[1]) || wrh;
        m_fl = (m_fl && reg_wdata[0]) || wrl;
      end else begin
        m_fh = m_fh || wrh; m_fl = m_fl || wrl;
      end
    end
    q_lo.push_back(evt_lo_i); q_hi.push_back(evt_hi_i);
    if (q_lo.size() > 4) begin void'(q_lo.pop_front()); void'(q_hi.pop_front()); end
  end

  function automatic int model_read(logic [1:0] a);
    case (a)
      2'd0: return {m_mode, m_enh, m_enl, m_fh, m_fl};
      2'd1: return m_lo;
      2'd2: return m_hi;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=0x%02h expected=0x%02h t=%0t",
               req, reg_addr, act, exp, $time);
    end
  endtask

  // one cycle: wait for falling edge, compare current read port with model
  task automatic tick();
    @(negedge clk);
    check(tag, reg_rdata, model_read(reg_addr));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd(logic [1:0] a, int exp, string req);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
    check(req, reg_rdata, model_read(a));
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic pulse_lo(int n);
    for (int i = 0; i < n; i++) begin
      evt_lo_i = 1; ticks(2); evt_lo_i = 0; ticks(2);
    end
    ticks(3);
  endtask

  task automatic pulse_hi(int n);
    for (int i = 0; i < n; i++) begin
      evt_hi_i = 1; ticks(2); evt_hi_i = 0; ticks(2);
    end
    ticks(3);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ticks(3);
    @(negedge clk); rst_n = 1;
    tick();
    // R1 and R2 reset values through every address
    tag = "R1";
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1"); rd(2, 8'h00, "R1"); rd(3, 8'h00, "R2");

    // R6 / R7: enables off, pulses ignored
    tag = "R6"; pulse_lo(3); rd(1, 0, "R6");
    wr(0, 8'h10); tag = "R7"; pulse_hi(2); rd(2, 0, "R7");

    // R3: cascade mode, low only, exact latency and single count per edge
    tag = "R3";
    wr(0, 8'h04); rd(0, 8'h04, "R2");
    reg_addr = 1;
    evt_lo_i = 1;
    tick(); tick(); check("R3", reg_rdata, 0);
    tick(); check("R3", reg_rdata, 1);
    ticks(20); check("R3", reg_rdata, 1);
    evt_lo_i = 0; ticks(3);
    pulse_lo(4); rd(1, 5, "R3");

    // R4 / R8: cascade wrap into high byte, high pin ignored
    tag = "R4";
    wr(0, 8'h0C); wr(1, 8'hFE);
    pulse_lo(3); rd(1, 1, "R4"); rd(2, 1, "R4"); rd(0, 8'h0D, "R8");
    pulse_hi(3); rd(2, 1, "R4");

    // R7: high enable off blocks the cascade
    tag = "R7";
    wr(0, 8'h05); wr(1, 8'hFF); pulse_lo(1);
    rd(1, 0, "R7"); rd(2, 1, "R7"); rd(0, 8'h05, "R8");

    // R8: writing 1 keeps, writing 0 clears
    tag = "R8";
    wr(0, 8'h05); rd(0, 8'h05, "R8");
    wr(0, 8'h04); rd(0, 8'h04, "R8");

    // R5: split mode, independent bytes, hi wrap sets hi flag
    tag = "R5";
    wr(0, 8'h1C); wr(1, 8'hFF); wr(2, 8'hFE);
    pulse_lo(1); rd(1, 0, "R5"); rd(2, 8'hFE, "R5");
    pulse_hi(3); rd(2, 1, "R5"); rd(0, 8'h1F, "R8");

    // R8: wrap coincident with clearing write keeps flag
    tag = "R8";
    wr(1, 8'hFF);
    evt_lo_i = 1; tick(); tick();
    wr(0, 8'h1C); evt_lo_i = 0;
    rd(0, 8'h1D, "R8"); rd(1, 0, "R8");

    // R9: write beats increment and suppresses wrap
    tag = "R9";
    wr(0, 8'h0C); wr(2, 8'h40);
    wr(1, 8'hFF);
    evt_lo_i = 1; tick(); tick();
    wr(1, 8'hFF); evt_lo_i = 0;
    rd(1, 8'hFF, "R9"); rd(2, 8'h40, "R9"); rd(0, 8'h0C, "R9");
    wr(0, 8'h1C);
    evt_hi_i = 1; tick(); tick();
    wr(2, 8'h22); evt_hi_i = 0;
    rd(2, 8'h22, "R9");
    ticks(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule